// File: doc/BRIEF.md
# SATA Port Link Power Manager

This block supervises one serial ATA port's link. It reads the link detection field and the interface power-state field, and it drives the control fields that the port's register file exposes. A check request evaluates whether the port is usable. If the interface is in a low-power state, the block raises a wake request and waits until the link is fully active again.

A reset request drives the device-initialization request for a fixed hold of one millisecond, counted in clock cycles. The block then releases the request and waits for the device to be detected again. A third request locks out interface power management by setting the two low bits of the control power field. Independently of any request, a port connect-change interrupt produces a write-one-to-clear mask for the two diagnostic bits of the error register.

The controller has four states:
- `ST_IDLE` accepts requests.
- `ST_WAKE_WAIT` waits for an active, established link.
- `ST_RST_HOLD` holds the initialization request.
- `ST_RST_WAIT` waits for detection to return.

The transitions are:
- accept-reset: `ST_IDLE` to `ST_RST_HOLD`.
- accept-wake: `ST_IDLE` to `ST_WAKE_WAIT`, for a check made while the link is in a low-power state.
- link-up: `ST_WAKE_WAIT` to `ST_IDLE`.
- hold-done: `ST_RST_HOLD` to `ST_RST_WAIT`.
- detect-back: `ST_RST_WAIT` to `ST_IDLE`.
- time-out: any wait state to `ST_IDLE`.

Top module: `link_pwr_mgr`

## Requirements
- R1: After reset, busy, ready, warning, timeout and wake are 0, the detect control field is 0, the power control field is 0 and the error clear mask is 0.
- R2: A check while idle, with the power state not partial (2) or slumber (6), sets ready to 1 one cycle later exactly when detection equals 3 and the power state equals 1 (active); otherwise ready is 0. Busy stays 0.
- R3: A check while idle with the power state partial (2) or slumber (6) raises wake and busy on the next cycle. Once detection reads 3 and the power state reads 1, wake and busy drop and ready becomes 1 on the following cycle.
- R4: A reset request while idle sets the detect control field to 1 for exactly HOLD_CYC = CLK_KHZ cycles, then sets it to 0. Busy stays high until detection reads 3; ready then equals (power state == 1).
- R5: A reset accepted while the command-start input is 1 sets the warning flag. An accepted check, or a reset accepted with start at 0, clears it.
- R6: A power-management lockout request while idle ORs 3 into the 4-bit power control field. The field then holds its value.
- R7: Connect-change input high in a cycle gives an error clear mask of 32'h0401_0000 (bits 26 and 16) on the next cycle; otherwise the mask is 0.
- R8: A wait state that is still unsatisfied after TMO_CYC cycles returns to idle. It sets timeout to 1 and clears wake and ready. Busy lasts exactly TMO_CYC cycles in this case.
- R9: Requests that arrive while busy are ignored. The power control field, the detect control field and the hold length are unaffected.
- R10: When strobes coincide in idle, reset takes priority over check, and check takes priority over lockout. Only the winner has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_det_i | input | 4 | Link detection field (3 = device present, link established) |
| link_pwr_i | input | 4 | Interface power state (1 active, 2 partial, 6 slumber) |
| cmd_start_i | input | 1 | Command-list processing start bit |
| conn_chg_i | input | 1 | Port connect-change interrupt status (bit 6) |
| chk_req_i | input | 1 | Check/wake request strobe |
| rst_req_i | input | 1 | Link reset request strobe |
| nopm_req_i | input | 1 | Power-management lockout request strobe |
| ready_o | output | 1 | Port active: established and in the active power state |
| busy_o | output | 1 | A request is in progress |
| warn_o | output | 1 | Reset was requested while command processing ran |
| tmo_o | output | 1 | Last wait ended by timeout |
| wake_o | output | 1 | Request for the active power state (command bit 28) |
| ctrl_det_o | output | 4 | Detect control field (1 = initialization request) |
| ctrl_ipm_o | output | 4 | Power-management control field |
| err_clr_o | output | 32 | Write-one-to-clear mask for the error register |

## Verification
The assertions assume the following about the inputs:
- Each request strobe is sampled on one edge.
- Link status fields are stable across each sampling edge.
- The start input is meaningful only when a reset is accepted.

The stimulus drives every input on the falling edge and holds each strobe for exactly one rising edge. It changes the link fields only while the block is idle or waiting, and it exercises every detection and power-state combination through the check request. Strobes sent during busy windows are placed so that the hold length and control fields remain directly observable at the ports.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAKE_WAIT,
        ST_RST_HOLD,
        ST_RST_WAIT
    } lpm_state_e;

    localparam logic [3:0]  DET_ESTAB    = 4'h3;
    localparam logic [3:0]  DET_INIT     = 4'h1;
    localparam logic [3:0]  PWR_ACTIVE   = 4'h1;
    localparam logic [3:0]  PWR_PARTIAL  = 4'h2;
    localparam logic [3:0]  PWR_SLUMBER  = 4'h6;
    localparam logic [3:0]  IPM_LOCK     = 4'h3;
    localparam logic [31:0] ERR_DIAG_CLR = 32'h0401_0000;
endpackage

// File: rtl/link_decode.sv
module link_decode
    import link_pm_pkg::*;
(
    input  logic [3:0] det_i,
    input  logic [3:0] pwr_i,
    output logic       estab_o,
    output logic       active_o,
    output logic       low_o
);
    always_comb begin
        estab_o  = (det_i == DET_ESTAB);
        active_o = (pwr_i == PWR_ACTIVE);
        low_o    = (pwr_i == PWR_PARTIAL) || (pwr_i == PWR_SLUMBER);
    end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic [W-1:0] lim_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else            cnt_q <= cnt_q + W'(1);
    end

    assign done_o = (cnt_q == lim_i - W'(1));
endmodule

// File: rtl/link_pwr_mgr.sv
module link_pwr_mgr
    import link_pm_pkg::*;
#(
    parameter int CLK_KHZ = 125000,
    parameter int TMO_CYC = 250000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [3:0]  link_det_i,
    input  logic [3:0]  link_pwr_i,
    input  logic        cmd_start_i,
    input  logic        conn_chg_i,
    input  logic        chk_req_i,
    input  logic        rst_req_i,
    input  logic        nopm_req_i,
    output logic        ready_o,
    output logic        busy_o,
    output logic        warn_o,
    output logic        tmo_o,
    output logic        wake_o,
    output logic [3:0]  ctrl_det_o,
    output logic [3:0]  ctrl_ipm_o,
    output logic [31:0] err_clr_o
);
    localparam int HOLD_CYC = CLK_KHZ;
    localparam int MAX_CYC  = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);

    lpm_state_e state_q, state_nx;
    logic       estab, active, low, done, tclr;
    logic [TW-1:0] lim;

    link_decode dec_i (
        .det_i    (link_det_i),
        .pwr_i    (link_pwr_i),
        .estab_o  (estab),
        .active_o (active),
        .low_o    (low)
    );

    assign lim  = (state_q == ST_RST_HOLD) ? TW'(HOLD_CYC) : TW'(TMO_CYC);
    assign tclr = (state_q == ST_IDLE) || (state_q != state_nx);

    cycle_timer #(.W(TW)) tmr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tclr),
        .lim_i  (lim),
        .done_o (done)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_req_i)             state_nx = ST_RST_HOLD;   // accept-reset
                else if (chk_req_i && low) state_nx = ST_WAKE_WAIT;  // accept-wake
            end
            ST_WAKE_WAIT: begin
                if ((estab && active) || done) state_nx = ST_IDLE;   // link-up / time-out
            end
            ST_RST_HOLD: begin
                if (done) state_nx = ST_RST_WAIT;                    // hold-done
            end
            ST_RST_WAIT: begin
                if (estab || done) state_nx = ST_IDLE;               // detect-back / time-out
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_nx;
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ready_o    <= 1'b0;
            warn_o     <= 1'b0;
            tmo_o      <= 1'b0;
            wake_o     <= 1'b0;
            ctrl_det_o <= '0;
            ctrl_ipm_o <= '0;
            err_clr_o  <= '0;
        end else begin
            err_clr_o <= conn_chg_i ? ERR_DIAG_CLR : '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (rst_req_i) begin
                        ctrl_det_o <= DET_INIT;
                        warn_o     <= cmd_start_i;
                        tmo_o      <= 1'b0;
                        ready_o    <= 1'b0;
                    end else if (chk_req_i) begin
                        warn_o  <= 1'b0;
                        tmo_o   <= 1'b0;
                        ready_o <= estab && active;
                        wake_o  <= low;
                    end else if (nopm_req_i) begin
                        ctrl_ipm_o <= ctrl_ipm_o | IPM_LOCK;
                    end
                end
                ST_WAKE_WAIT: begin
                    if (estab && active) begin
                        wake_o  <= 1'b0;
                        ready_o <= 1'b1;
                    end else if (done) begin
                        wake_o  <= 1'b0;
                        tmo_o   <= 1'b1;
                        ready_o <= 1'b0;
                    end
                end
                ST_RST_HOLD: begin
                    if (done) ctrl_det_o <= '0;
                end
                ST_RST_WAIT: begin
                    if (estab)     ready_o <= active;
                    else if (done) tmo_o   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/link_pwr_mgr_chk.sv
module link_pwr_mgr_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [3:0]  link_det_i,
    input logic        cmd_start_i,
    input logic        conn_chg_i,
    input logic        rst_req_i,
    input logic        ready_o,
    input logic        busy_o,
    input logic        warn_o,
    input logic        tmo_o,
    input logic        wake_o,
    input logic [3:0]  ctrl_det_o,
    input logic [3:0]  ctrl_ipm_o,
    input logic [31:0] err_clr_o
);
    AST_READY_NEEDS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ready_o) |-> $past(link_det_i) == 4'h3); // R2
    AST_WAKE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) wake_o |-> busy_o); // R3
    AST_INIT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_det_o != 4'h0) |-> busy_o); // R4
    AST_WARN_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(warn_o) |-> $past(cmd_start_i)); // R5
    AST_IPM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_ipm_o == 4'h3) |=> (ctrl_ipm_o == 4'h3)); // R6
    AST_ERR_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) conn_chg_i |=> (err_clr_o == 32'h0401_0000)); // R7
    AST_ERR_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) !conn_chg_i |=> (err_clr_o == 32'h0)); // R7
    AST_TMO_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) tmo_o |-> !busy_o); // R8
    AST_BUSY_NO_NEW_RST: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o |=> !$rose(ctrl_det_o[0])); // R9
    AST_BUSY_NO_IPM: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_o && ctrl_ipm_o == 4'h0) |=> (ctrl_ipm_o == 4'h0)); // R9
    AST_RST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_o && rst_req_i) |=> (ctrl_det_o == 4'h1 && !wake_o)); // R10
endmodule

bind link_pwr_mgr link_pwr_mgr_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_det_i  (link_det_i),
    .cmd_start_i (cmd_start_i),
    .conn_chg_i  (conn_chg_i),
    .rst_req_i   (rst_req_i),
    .ready_o     (ready_o),
    .busy_o      (busy_o),
    .warn_o      (warn_o),
    .tmo_o       (tmo_o),
    .wake_o      (wake_o),
    .ctrl_det_o  (ctrl_det_o),
    .ctrl_ipm_o  (ctrl_ipm_o),
    .err_clr_o   (err_clr_o)
);

// File: tb/link_pwr_mgr_tb_top.sv
`timescale 1ns/1ps
module link_pwr_mgr_tb_top;
    localparam int KHZ = 6;
    localparam int TMO = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  det = 4'h0, pwr = 4'h0;
    logic        start = 1'b0, chg = 1'b0, chk = 1'b0, rreq = 1'b0, nopm = 1'b0;
    logic        ready, busy, warn, tmo, wake;
    logic [3:0]  cdet, cipm;
    logic [31:0] eclr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    link_pwr_mgr #(.CLK_KHZ(KHZ), .TMO_CYC(TMO)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .link_det_i(det), .link_pwr_i(pwr),
        .cmd_start_i(start), .conn_chg_i(chg), .chk_req_i(chk),
        .rst_req_i(rreq), .nopm_req_i(nopm), .ready_o(ready), .busy_o(busy),
        .warn_o(warn), .tmo_o(tmo), .wake_o(wake), .ctrl_det_o(cdet),
        .ctrl_ipm_o(cipm), .err_clr_o(eclr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic c, input logic r, input logic n);
        chk = c; rreq = r; nopm = n;
        @(negedge clk);
        chk = 1'b0; rreq = 1'b0; nopm = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flags", {27'd0, ready, busy, warn, tmo, wake}, 32'd0);
        check("R1 ctrl", {24'd0, cdet, cipm}, 32'd0);
        check("R1 mask", eclr, 32'd0);

        // R2 / R3 sweep over every detect and power code
        for (int d = 0; d < 16; d++) begin
            for (int p = 0; p < 16; p++) begin
                det = 4'(d); pwr = 4'(p);
                pulse(1'b1, 1'b0, 1'b0);
                if (p == 2 || p == 6) begin
                    check("R3 wake", {30'd0, wake, busy}, 32'd3);
                    det = 4'h3; pwr = 4'h1;
                    @(negedge clk);
                    check("R3 done", {29'd0, ready, wake, busy}, 32'd4);
                end else begin
                    check("R2 ready", {30'd0, ready, busy},
                          {30'd0, (d == 3 && p == 1), 1'b0});
                end
            end
        end

        // R8 wake timeout
        det = 4'h0; pwr = 4'h6;
        pulse(1'b1, 1'b0, 1'b0);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        check("R8 wake len", n, TMO);
        check("R8 wake flags", {29'd0, tmo, wake, ready}, 32'd4);

        // R4 reset hold with R9 ignored strobes and R5 warning
        det = 4'h0; pwr = 4'h1; start = 1'b1;
        pulse(1'b0, 1'b1, 1'b0);
        start = 1'b0;
        check("R5 warn set", warn, 1);
        check("R8 tmo cleared", tmo, 0);
        n = 0;
        while (cdet == 4'h1 && n < 100) begin
            n++;
            if (n == 2) begin chk = 1'b1; nopm = 1'b1; end
            if (n == 3) begin rreq = 1'b1; end
            @(negedge clk);
            chk = 1'b0; nopm = 1'b0; rreq = 1'b0;
        end
        check("R4 hold len", n, KHZ);
        check("R9 ipm untouched", cipm, 0);
        check("R4 ctrl released", {28'd0, cdet}, 32'd0);
        check("R4 busy wait", busy, 1);
        repeat (2) @(negedge clk);
        det = 4'h3; pwr = 4'h1;
        @(negedge clk);
        check("R4 done", {30'd0, ready, busy}, 32'd2);

        // R5 warning cleared by reset without start; R8 reset-wait timeout
        det = 4'h0;
        pulse(1'b0, 1'b1, 1'b0);
        check("R5 warn clear", warn, 0);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        check("R8 rst len", n, KHZ + TMO);
        check("R8 rst tmo", {30'd0, tmo, ready}, 32'd2);

        // R10 priority
        det = 4'h3; pwr = 4'h6;
        pulse(1'b1, 1'b1, 1'b1);
        check("R10 reset wins", {26'd0, cdet, wake, cipm != 0}, 32'h4);
        while (busy) @(negedge clk);
        pwr = 4'h1;
        pulse(1'b1, 1'b0, 1'b1);
        check("R10 check over lock", {30'd0, ready, cipm != 0}, 32'd2);

        // R6 lockout
        pulse(1'b0, 1'b0, 1'b1);
        check("R6 ipm set", cipm, 3);
        pulse(1'b0, 1'b0, 1'b1);
        check("R6 ipm hold", cipm, 3);

        // R7 error clear mask
        chg = 1'b1;
        @(negedge clk);
        chg = 1'b0;
        check("R7 mask on", eclr, 32'h0401_0000);
        @(negedge clk);
        check("R7 mask off", eclr, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule